// File: doc/BRIEF.md
# Inter-Processor Send Command Router

This block sits on the write and read port that a core uses to reach its IO-configuration register space. Ordinary accesses are forwarded to a shared per-core register space. Before forwarding, an address whose page (bits 15:8) is 0x10 or 0x18 is shifted into the issuing core's own copy of that page.

Three write addresses are treated as command words aimed at another core:

- A write to the interrupt-send address raises one interrupt vector bit on the target core.
- A write to the mailbox-send address becomes a 32-bit store into one of the target core's mailbox slots.
- A write to the any-send address becomes up to four single-byte stores, one per cycle, each gated by a mask bit.

Commands arrive on a valid/ready handshake. Results leave on two registered outputs: a one-cycle interrupt-set strobe, and a downstream access bus that carries the core, address, data, size and direction. Every output appears in the cycle after the command is accepted.

Top module: `ipi_send_router`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with no accepted command and no byte slot in progress, `busValid` and `ipiValid` are 0 and `cmdReady` is 1.
- R2: A write (cmdOp 4..7) to address 0x1040 produces, in the next cycle, one `ipiValid` pulse. `ipiCore` is data bits 25:16 and `ipiMask` has only bit (data bits 4:0) set. No bus access is issued for this command.
- R3: A write to address 0x1048 produces, in the next cycle, a 4-byte bus write. `busCore` is data bits 25:16 and `busData` is data bits 63:32 zero-extended. `busAddr` is 0x1020 plus (data & 0x1c), plus (target core bits 1:0) shifted left by 8.
- R4: A write to address 0x1158 occupies four consecutive cycles, the first being the cycle after acceptance. Slot i (i = 0..3) carries address data[15:0]+i (16-bit wrap), byte (data[63:32] >> 8*i) & 0xff, size 1, and core data[25:16]. No page remap is applied. `busValid` is raised for slot i only when data bit 59+i is 0.
- R5: After an any-send is accepted, `cmdReady` is 0 for exactly three cycles. A command presented while `cmdReady` is 0 has no effect.
- R6: Any other write (cmdOp 4,5,6,7 giving 1,2,4,8 bytes) is forwarded in the next cycle with `busWrite`=1, `busCore`=`srcCore` and unchanged data. The address is remapped by `srcCore` bits 1:0 shifted left by 8 when bits 15:8 are 0x10 or 0x18, and left alone otherwise.
- R7: A read (cmdOp 0,1,2,3 giving 1,2,4,8 bytes) is forwarded in the next cycle with `busWrite`=0, `busData`=0 and `busCore`=`srcCore`. The address is remapped as in R6.
- R8: A read aimed at one of the three send addresses is an ordinary remapped read and triggers no send action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Router can take a command |
| cmdOp | input | 3 | Bit 2 = write; bits 1:0 = log2 of size in bytes |
| cmdAddr | input | 16 | Register address |
| cmdData | input | 64 | Write data or packed send command |
| srcCore | input | 10 | Index of the issuing core |
| ipiValid | output | 1 | Interrupt-set strobe |
| ipiCore | output | 10 | Target core of the strobe |
| ipiMask | output | 32 | One-hot vector to set |
| busValid | output | 1 | Downstream access strobe |
| busWrite | output | 1 | 1 = write, 0 = read |
| busCore | output | 10 | Core whose register space is accessed |
| busAddr | output | 16 | Downstream address |
| busData | output | 64 | Downstream write data |
| busSize | output | 4 | Access size in bytes (1, 2, 4, 8) |

## Verification
The hardest situation to reach is a new command that is presented while an any-send is still stepping through its byte slots. Reaching it means the input must be held valid during the three stall cycles.

The stimulus issues an any-send and then, without looking at `cmdReady`, drives an interrupt-send for exactly those three cycles. The reference model sees no strobe for it. Masks of 0101, 0000 and 1111 and a start address that wraps past 0xFFFF cover the gated and wrap-around byte slots. A command placed back to back after a fully masked sequence shows that `cmdReady` returns on the right cycle.

// File: rtl/ipisr_pkg.sv
package ipisr_pkg;

  // Command addresses decoded by the router
  localparam logic [15:0] IPI_SEND_ADDR  = 16'h1040;
  localparam logic [15:0] MAIL_SEND_ADDR = 16'h1048;
  localparam logic [15:0] ANY_SEND_ADDR  = 16'h1158;
  localparam logic [15:0] MAIL_BASE_ADDR = 16'h1020;

  // Pages that are aliased per core
  localparam logic [7:0] ALIAS_PAGE_A = 8'h10;
  localparam logic [7:0] ALIAS_PAGE_B = 8'h18;

  // Byte slots of an any-send sequence
  localparam int ANY_SLOTS  = 4;
  localparam int SLOT_IDX_W = $clog2(ANY_SLOTS);

  // Strobes from control to datapath
  typedef struct packed {
    logic                  doIpi;
    logic                  doMail;
    logic                  doAnyFirst;
    logic                  doAnyNext;
    logic                  doPlain;
    logic [SLOT_IDX_W-1:0] slot;
  } ctrl_strobes_t;

endpackage

// File: rtl/ipisr_ctrl.sv
module ipisr_ctrl
  import ipisr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdReady,
  output ctrl_strobes_t     strb
);

  logic                  busyQ;
  logic [SLOT_IDX_W-1:0] slotQ;
  logic                  accept;
  logic                  hitIpi, hitMail, hitAny;

  assign cmdReady = !busyQ;
  assign accept   = cmdValid && !busyQ;

  assign hitIpi  = isWrite && (cmdAddr == ADDR_W'(IPI_SEND_ADDR));
  assign hitMail = isWrite && (cmdAddr == ADDR_W'(MAIL_SEND_ADDR));
  assign hitAny  = isWrite && (cmdAddr == ADDR_W'(ANY_SEND_ADDR));

  always_comb begin
    strb.doIpi      = accept && hitIpi;
    strb.doMail     = accept && hitMail;
    strb.doAnyFirst = accept && hitAny;
    strb.doPlain    = accept && !hitIpi && !hitMail && !hitAny;
    strb.doAnyNext  = busyQ;
    strb.slot       = busyQ ? slotQ : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      slotQ <= '0;
    end else if (strb.doAnyFirst) begin
      busyQ <= 1'b1;
      slotQ <= SLOT_IDX_W'(1);
    end else if (busyQ) begin
      slotQ <= slotQ + SLOT_IDX_W'(1);
      if (slotQ == SLOT_IDX_W'(ANY_SLOTS - 1)) busyQ <= 1'b0;
    end
  end

  // R5
  any_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doAnyFirst |=> !cmdReady ##1 !cmdReady ##1 !cmdReady ##1 cmdReady);

  // R5
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |-> !(strb.doIpi || strb.doMail || strb.doAnyFirst || strb.doPlain));

endmodule

// File: rtl/ipisr_datapath.sv
module ipisr_datapath
  import ipisr_pkg::*;
#(
  parameter int CORE_W = 10,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int VEC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strb,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [CORE_W-1:0] srcCore,
  output logic              ipiValid,
  output logic [CORE_W-1:0] ipiCore,
  output logic [VEC_W-1:0]  ipiMask,
  output logic              busValid,
  output logic              busWrite,
  output logic [CORE_W-1:0] busCore,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic [3:0]        busSize
);

  localparam int PAY_W     = DATA_W / 2;
  localparam int VEC_IDX_W = $clog2(VEC_W);
  localparam int CORE_LSB  = 16;
  localparam int MASK_LSB  = PAY_W + 27;

  logic [CORE_W-1:0]    anyCoreQ;
  logic [ADDR_W-1:0]    anyAddrQ;
  logic [PAY_W-1:0]     anyPayQ;
  logic [ANY_SLOTS-1:0] anyMaskQ;

  logic [CORE_W-1:0]    tgtCore;
  logic [VEC_IDX_W-1:0] vecIdx;
  logic [ADDR_W-1:0]    mailAddr;
  logic [CORE_W-1:0]    selCore;
  logic [ADDR_W-1:0]    selAddr;
  logic [PAY_W-1:0]     selPay;
  logic [ANY_SLOTS-1:0] selMask;
  logic [ADDR_W-1:0]    slotAddr;
  logic [7:0]           slotByte;
  logic                 slotOn;
  logic                 anyStep;
  logic                 unusedBits;

  function automatic logic [ADDR_W-1:0] aliasAddr(input logic [ADDR_W-1:0] a,
                                                  input logic [CORE_W-1:0] c);
    logic [7:0] page;
    page = a[15:8];
    if (page == ALIAS_PAGE_A || page == ALIAS_PAGE_B)
      return a + (ADDR_W'(c[1:0]) << 8);
    return a;
  endfunction

  assign tgtCore  = cmdData[CORE_LSB +: CORE_W];
  assign vecIdx   = cmdData[VEC_IDX_W-1:0];
  assign mailAddr = ADDR_W'(MAIL_BASE_ADDR) + ADDR_W'({cmdData[4:2], 2'b00});

  assign anyStep  = strb.doAnyFirst || strb.doAnyNext;
  assign selCore  = strb.doAnyFirst ? tgtCore : anyCoreQ;
  assign selAddr  = strb.doAnyFirst ? cmdData[ADDR_W-1:0] : anyAddrQ;
  assign selPay   = strb.doAnyFirst ? cmdData[DATA_W-1:PAY_W] : anyPayQ;
  assign selMask  = strb.doAnyFirst ? cmdData[MASK_LSB +: ANY_SLOTS] : anyMaskQ;
  assign slotAddr = selAddr + ADDR_W'(strb.slot);
  assign slotByte = 8'(selPay >> {strb.slot, 3'b000});
  assign slotOn   = !selMask[strb.slot];

  assign unusedBits = ^cmdData[PAY_W-1:CORE_LSB+CORE_W];

  // Latched command for the later byte slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anyCoreQ <= '0;
      anyAddrQ <= '0;
      anyPayQ  <= '0;
      anyMaskQ <= '0;
    end else if (strb.doAnyFirst) begin
      anyCoreQ <= tgtCore;
      anyAddrQ <= cmdData[ADDR_W-1:0];
      anyPayQ  <= cmdData[DATA_W-1:PAY_W];
      anyMaskQ <= cmdData[MASK_LSB +: ANY_SLOTS];
    end
  end

  // Interrupt-set strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ipiValid <= 1'b0;
      ipiCore  <= '0;
      ipiMask  <= '0;
    end else begin
      ipiValid <= strb.doIpi;
      if (strb.doIpi) begin
        ipiCore <= tgtCore;
        ipiMask <= VEC_W'(1) << vecIdx;
      end
    end
  end

  // Downstream access bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busValid <= 1'b0;
      busWrite <= 1'b0;
      busCore  <= '0;
      busAddr  <= '0;
      busData  <= '0;
      busSize  <= '0;
    end else begin
      busValid <= strb.doMail || strb.doPlain || (anyStep && slotOn);
      if (strb.doMail) begin
        busWrite <= 1'b1;
        busCore  <= tgtCore;
        busAddr  <= aliasAddr(mailAddr, tgtCore);
        busData  <= DATA_W'(cmdData[DATA_W-1:PAY_W]);
        busSize  <= 4'd4;
      end else if (strb.doPlain) begin
        busWrite <= cmdOp[2];
        busCore  <= srcCore;
        busAddr  <= aliasAddr(cmdAddr, srcCore);
        busData  <= cmdOp[2] ? cmdData : '0;
        busSize  <= 4'd1 << cmdOp[1:0];
      end else if (anyStep) begin
        busWrite <= 1'b1;
        busCore  <= selCore;
        busAddr  <= slotAddr;
        busData  <= DATA_W'(slotByte);
        busSize  <= 4'd1;
      end
    end
  end

  // R2
  ipi_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ipiValid |-> $countones(ipiMask) == 1);

  // R2
  ipi_nobus_chk: assert property (@(posedge clk) disable iff (!rstN)
    ipiValid |-> !busValid);

  // R6
  size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> $countones(busSize) == 1);

  // R4
  any_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doAnyNext |=> busAddr == $past(busAddr) + ADDR_W'(1));

  // R4
  any_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doAnyNext |=> (!busValid || busSize == 4'd1));

endmodule

// File: rtl/ipi_send_router.sv
module ipi_send_router
  import ipisr_pkg::*;
#(
  parameter int CORE_W = 10,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int VEC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [CORE_W-1:0] srcCore,
  output logic              ipiValid,
  output logic [CORE_W-1:0] ipiCore,
  output logic [VEC_W-1:0]  ipiMask,
  output logic              busValid,
  output logic              busWrite,
  output logic [CORE_W-1:0] busCore,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic [3:0]        busSize
);

  ctrl_strobes_t strb;

  ipisr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .isWrite  (cmdOp[2]),
    .cmdAddr  (cmdAddr),
    .cmdReady (cmdReady),
    .strb     (strb)
  );

  ipisr_datapath #(
    .CORE_W (CORE_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .VEC_W  (VEC_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdOp    (cmdOp),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .srcCore  (srcCore),
    .ipiValid (ipiValid),
    .ipiCore  (ipiCore),
    .ipiMask  (ipiMask),
    .busValid (busValid),
    .busWrite (busWrite),
    .busCore  (busCore),
    .busAddr  (busAddr),
    .busData  (busData),
    .busSize  (busSize)
  );

endmodule

// File: tb/sim_ipi_send_router.sv
`timescale 1ns/1ps
module sim_ipi_send_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = '0;
  logic [15:0] cmdAddr = '0;
  logic [63:0] cmdData = '0;
  logic [9:0]  srcCore = '0;
  logic        ipiValid;
  logic [9:0]  ipiCore;
  logic [31:0] ipiMask;
  logic        busValid, busWrite;
  logic [9:0]  busCore;
  logic [15:0] busAddr;
  logic [63:0] busData;
  logic [3:0]  busSize;

  int nTests = 0;
  int nFail = 0;
  bit checkOn = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipi_send_router u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData), .srcCore(srcCore),
    .ipiValid(ipiValid), .ipiCore(ipiCore), .ipiMask(ipiMask),
    .busValid(busValid), .busWrite(busWrite), .busCore(busCore),
    .busAddr(busAddr), .busData(busData), .busSize(busSize)
  );

  // ---------------- reference model ----------------
  typedef struct {
    bit          v;
    logic [9:0]  core;
    logic [15:0] addr;
    logic [63:0] data;
  } slot_t;
  slot_t pend[$];

  bit          eReady = 1, eBusV = 0, eBusW = 0, eIpiV = 0;
  logic [9:0]  eCore = '0, eIpiCore = '0;
  logic [15:0] eAddr = '0;
  logic [63:0] eData = '0;
  logic [3:0]  eSize = '0;
  logic [31:0] eIpiMask = '0;
  string       eReq = "R1";

  function automatic logic [15:0] refAlias(logic [15:0] a, logic [9:0] c);
    int page = int'(a) / 256;
    if (page == 16 || page == 24) return a + 16'(int'(c) % 4 * 256);
    return a;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pend.delete();
      eReady <= 1; eBusV <= 0; eIpiV <= 0; eReq <= "R1";
    end else begin
      eBusV <= 0; eIpiV <= 0; eReady <= 1; eReq <= "R1";
      if (pend.size() > 0) begin
        automatic slot_t s = pend.pop_front();
        eBusV <= s.v; eBusW <= 1; eCore <= s.core; eAddr <= s.addr;
        eData <= s.data; eSize <= 1;
        eReq <= cmdValid ? "R5" : "R4";
        eReady <= (pend.size() == 0);
      end else if (cmdValid) begin
        automatic bit wr = (cmdOp >= 4);
        automatic logic [63:0] d = cmdData;
        automatic logic [9:0] t = d[25:16];
        if (wr && cmdAddr == 16'h1040) begin
          eIpiV <= 1; eIpiCore <= t; eIpiMask <= 32'h1 << d[4:0]; eReq <= "R2";
        end else if (wr && cmdAddr == 16'h1048) begin
          eBusV <= 1; eBusW <= 1; eCore <= t;
          eAddr <= refAlias(16'h1020 + 16'(d & 64'h1c), t);
          eData <= d >> 32; eSize <= 4; eReq <= "R3";
        end else if (wr && cmdAddr == 16'h1158) begin
          for (int i = 0; i < 4; i++) begin
            automatic slot_t s;
            s.v = ((d >> (59 + i)) & 64'h1) == 0;
            s.core = t;
            s.addr = d[15:0] + 16'(i);
            s.data = (d >> (32 + 8 * i)) & 64'hff;
            pend.push_back(s);
          end
          begin
            automatic slot_t s0 = pend.pop_front();
            eBusV <= s0.v; eBusW <= 1; eCore <= s0.core; eAddr <= s0.addr;
            eData <= s0.data; eSize <= 1; eReq <= "R4"; eReady <= 0;
          end
        end else begin
          eBusV <= 1; eBusW <= wr; eCore <= srcCore;
          eAddr <= refAlias(cmdAddr, srcCore);
          eData <= wr ? d : 64'h0;
          eSize <= 4'(1 << (int'(cmdOp) % 4));
          if (!wr && (cmdAddr == 16'h1040 || cmdAddr == 16'h1048 || cmdAddr == 16'h1158))
            eReq <= "R8";
          else
            eReq <= wr ? "R6" : "R7";
        end
      end
    end
  end

  // ---------------- comparison every cycle ----------------
  always @(negedge clk) begin
    if (checkOn && !done) begin
      automatic bit bad = 0;
      nTests++;
      if (cmdReady !== eReady) begin
        bad = 1; $display("FAIL R5 cmdReady act %0b exp %0b", cmdReady, eReady);
      end
      if (busValid !== eBusV) begin
        bad = 1; $display("FAIL %s busValid act %0b exp %0b", eReq, busValid, eBusV);
      end else if (eBusV) begin
        if (busWrite !== eBusW) begin
          bad = 1; $display("FAIL %s busWrite act %0b exp %0b", eReq, busWrite, eBusW);
        end
        if (busCore !== eCore) begin
          bad = 1; $display("FAIL %s busCore act %h exp %h", eReq, busCore, eCore);
        end
        if (busAddr !== eAddr) begin
          bad = 1; $display("FAIL %s busAddr act %h exp %h", eReq, busAddr, eAddr);
        end
        if (busData !== eData) begin
          bad = 1; $display("FAIL %s busData act %h exp %h", eReq, busData, eData);
        end
        if (busSize !== eSize) begin
          bad = 1; $display("FAIL %s busSize act %0d exp %0d", eReq, busSize, eSize);
        end
      end
      if (ipiValid !== eIpiV) begin
        bad = 1; $display("FAIL %s ipiValid act %0b exp %0b", eReq, ipiValid, eIpiV);
      end else if (eIpiV) begin
        if (ipiCore !== eIpiCore) begin
          bad = 1; $display("FAIL %s ipiCore act %h exp %h", eReq, ipiCore, eIpiCore);
        end
        if (ipiMask !== eIpiMask) begin
          bad = 1; $display("FAIL %s ipiMask act %h exp %h", eReq, ipiMask, eIpiMask);
        end
      end
      if (bad) nFail++;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [63:0] mk(logic [9:0] core, logic [15:0] lo, logic [31:0] hi);
    return {hi, 6'b0, core, lo};
  endfunction

  task automatic drive(input logic [2:0] op, input logic [15:0] a,
                       input logic [63:0] d, input logic [9:0] c);
    cmdValid = 0;
    while (!cmdReady) @(negedge clk);
    cmdOp = op; cmdAddr = a; cmdData = d; srcCore = c; cmdValid = 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    cmdValid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOn = 1;            // R1: reset state compared here
    @(negedge clk);
    rstN = 1;
    idle(2);                // R1: idle after reset

    // R2: interrupt sends
    drive(3'd6, 16'h1040, mk(10'h2A3, 16'h0005, 32'hDEAD_BEEF), 10'd1);
    drive(3'd7, 16'h1040, mk(10'h001, 16'h001F, 32'h0), 10'd2);
    drive(3'd4, 16'h1040, mk(10'h3FF, 16'h0000, 32'h0), 10'd3);
    idle(1);

    // R3: mailbox sends
    drive(3'd7, 16'h1048, mk(10'h0E6, 16'h0014, 32'hCAFE_F00D), 10'd0);
    drive(3'd6, 16'h1048, mk(10'h101, 16'h001C, 32'h1234_5678), 10'd3);
    idle(1);

    // R4 / R5: mask 0101, then hold a command during the stall
    drive(3'd7, 16'h1158, mk(10'h055, 16'h1234, 32'h2B44_5566), 10'd0);
    cmdOp = 3'd6; cmdAddr = 16'h1040; cmdData = mk(10'h007, 16'h0003, 32'h0);
    cmdValid = 1;
    repeat (3) @(negedge clk);
    idle(2);

    // R4: mask 0000 with address wrap, then mask 1111 with a command behind it
    drive(3'd7, 16'h1158, mk(10'h005, 16'hFFFE, 32'h0312_3456), 10'd2);
    drive(3'd7, 16'h1158, mk(10'h00A, 16'h0100, 32'h7955_AA11), 10'd2);
    drive(3'd7, 16'h1048, mk(10'h003, 16'h0008, 32'hA5A5_0F0F), 10'd1);
    idle(2);

    // R6: forwarded writes of every size
    for (int op = 4; op < 8; op++)
      drive(3'(op), 16'h1804, 64'h0123_4567_89AB_CDEF + 64'(op), 10'd3);
    drive(3'd6, 16'h2000, 64'h1111_2222_3333_4444, 10'd2);
    drive(3'd5, 16'h10F0, 64'h0000_0000_0000_BEEF, 10'd1);
    drive(3'd7, 16'h1900, 64'hFFFF_0000_FFFF_0000, 10'd3);
    idle(1);

    // R7: reads of every size
    for (int op = 0; op < 4; op++) drive(3'(op), 16'h1000, 64'hFFFF, 10'd2);
    drive(3'd2, 16'h1800, 64'h0, 10'd1);
    drive(3'd3, 16'h0420, 64'h0, 10'd3);

    // R8: reads at the send addresses
    drive(3'd2, 16'h1040, mk(10'h002, 16'h0004, 32'h0), 10'd1);
    drive(3'd3, 16'h1158, mk(10'h002, 16'h0010, 32'h0), 10'd2);
    drive(3'd0, 16'h1048, mk(10'h002, 16'h0010, 32'h0), 10'd3);
    idle(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog act timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule